// File: doc/BRIEF.md
# Raster Timing and RGB24 Pixel Output

This block turns a pixel clock into raster video for a panel or video DAC. Two position counters, one per axis, walk every frame through four regions in a fixed order: visible pixels, front porch, sync pulse and back porch. The sync pulses and a data-enable strobe are decoded from those positions. Each line is a separate run through the horizontal regions, and the vertical regions count whole lines.

The host supplies the length of every interval on each axis and the sync polarities. The block copies them into shadow registers only at a frame boundary, so a frame in progress never changes shape. During visible pixels the block pulls one 24-bit pixel per clock from an upstream buffer through a valid/ready handshake. If the buffer has nothing ready, the pixel is painted black and a sticky flag records the starvation.

A test mode paints eight equal colour bars without touching the buffer. A power-save mode parks the outputs in their idle state and freezes the raster where it stands. All state uses the rising clock edge and an asynchronous active-low reset.

Top module: `vid_raster_out`

## Requirements
- R1: A line lasts h_act+h_fp+h_sync+h_bp clocks, with its regions in this order: visible, front porch, sync, back porch. A frame lasts v_act+v_fp+v_sync+v_bp lines in the same region order. Every interval must be at least 1.
- R2: `de` is high exactly for pixels that are visible on both axes. Whenever `de` is low, `rgb` is zero.
- R3: `hsync` is at its active level during the horizontal sync region of every line. `vsync` is at its active level for every clock of the lines in the vertical sync region. A polarity bit of 1 makes the active level high, and 0 makes it low.
- R4: Interval lengths and polarity bits are sampled on the first clock after reset, and again on the clock where both counters wrap to zero. Changes at any other time only take effect at the next frame.
- R5: `pix_ready` is high exactly in visible positions when neither test mode nor power-save is set. The pixel on `pix_data` in a clock with `pix_valid` high and `pix_ready` high appears on `rgb` one clock later, with `de` high.
- R6: A visible position with `pix_ready` high and `pix_valid` low shows black. It also sets `underflow`, which stays high until reset.
- R7: In test mode `pix_ready` stays low. Visible pixel x shows bar k = floor(8*x/h_act). `rgb` is {R,G,B} in bits [23:16], [15:8] and [7:0]. R is 0xFF when bit 1 of k is 0, G is 0xFF when bit 2 of k is 0, and B is 0xFF when bit 0 of k is 0. Each channel is 0x00 otherwise. Test mode needs h_act >= 8.
- R8: While `psave_en` is high, from the next clock on, both syncs are at their inactive level, `de` is low and `rgb` is zero. The counters hold their position and resume from it when `psave_en` drops.
- R9: During reset `hsync`, `vsync`, `de`, `rgb`, `underflow` and `pix_ready` are all zero. The first visible pixel is requested on the second clock after reset is released.
- R10: Interval fields are 12 bits wide. Active sizes from 320x240 up to 1920x1200 are supported, including a 1920-pixel visible line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| h_act | input | 12 | Visible pixels per line |
| h_fp | input | 12 | Horizontal front porch length |
| h_sync | input | 12 | Horizontal sync length |
| h_bp | input | 12 | Horizontal back porch length |
| v_act | input | 12 | Visible lines per frame |
| v_fp | input | 12 | Vertical front porch lines |
| v_sync | input | 12 | Vertical sync lines |
| v_bp | input | 12 | Vertical back porch lines |
| hs_pol | input | 1 | 1 = horizontal sync active high |
| vs_pol | input | 1 | 1 = vertical sync active high |
| test_en | input | 1 | Colour-bar test mode |
| psave_en | input | 1 | Power-save mode |
| pix_valid | input | 1 | Upstream pixel available |
| pix_data | input | 24 | Upstream pixel, {R,G,B} |
| pix_ready | output | 1 | Pixel taken this clock |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| rgb | output | 24 | Output pixel, {R,G,B} |
| underflow | output | 1 | Sticky buffer-starvation flag |

## Verification
The assertions check these properties on every cycle:
- each counter stays inside its frame and returns to zero after its last position;
- the counters hold still and the outputs go idle in power-save;
- shadow timing moves only at a load point;
- blanked pixels are black;
- test mode never pulls a pixel;
- the bar index stays in range;
- the underflow flag never falls.

Only the bench scenarios can show the exact clock on which each sync edge and each `de` edge lands. They also show that a reprogrammed geometry waits for the frame boundary, that the bar colours sit where the formula places them across a full 1920-pixel line, and that every accepted pixel comes out unchanged one clock later.

// File: rtl/vid_pkg.sv
package vid_pkg;

  localparam int CW = 12;
  localparam int PW = CW + 2;
  localparam int BAR_LG = 3;

  typedef logic [CW-1:0] span_t;
  typedef logic [PW-1:0] pos_t;

  typedef struct packed {
    span_t act;
    span_t fp;
    span_t sy;
    span_t bp;
    logic  pol;
  } axis_cfg_t;

  typedef enum logic [1:0] {
    RG_ACT = 2'd0,
    RG_FP  = 2'd1,
    RG_SY  = 2'd2,
    RG_BP  = 2'd3
  } region_e;

  function automatic pos_t axis_total(axis_cfg_t c);
    return pos_t'(c.act) + pos_t'(c.fp) + pos_t'(c.sy) + pos_t'(c.bp);
  endfunction

  function automatic region_e axis_region(pos_t p, axis_cfg_t c);
    pos_t e_act, e_fp, e_sy;
    e_act = pos_t'(c.act);
    e_fp  = e_act + pos_t'(c.fp);
    e_sy  = e_fp + pos_t'(c.sy);
    if (p < e_act)     return RG_ACT;
    else if (p < e_fp) return RG_FP;
    else if (p < e_sy) return RG_SY;
    else               return RG_BP;
  endfunction

  function automatic logic [23:0] bar_rgb(logic [BAR_LG-1:0] b);
    return {{8{~b[1]}}, {8{~b[2]}}, {8{~b[0]}}};
  endfunction

endpackage

// File: rtl/vid_axis_ctr.sv
module vid_axis_ctr
  import vid_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      live,
  input  logic      step,
  input  axis_cfg_t cfg,
  output pos_t      pos,
  output logic      last,
  output region_e   region
);

  pos_t total;

  always_comb begin
    total  = axis_total(cfg);
    last   = (pos == total - pos_t'(1));
    region = axis_region(pos, cfg);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pos <= '0;
    else if (step) pos <= last ? '0 : pos + pos_t'(1);
  end

  // R1: position never leaves the programmed frame
  assert_pos_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> (pos < total));

  // R1: a stepped last position returns to zero
  assert_wrap_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last) |=> (pos == '0));

  // R8: no step, no movement
  assert_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(pos));

endmodule

// File: rtl/vid_bar_gen.sv
module vid_bar_gen
  import vid_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              line_wrap,
  input  logic              in_act,
  input  span_t             width,
  output logic [BAR_LG:0]   bar
);

  localparam int AW = CW + 1;
  localparam logic [AW-1:0] NBARS = AW'(1 << BAR_LG);

  logic [AW-1:0] acc;
  logic [AW-1:0] acc_inc;
  logic          roll;

  always_comb begin
    acc_inc = acc + NBARS;
    roll    = (acc_inc >= AW'(width));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      bar <= '0;
    end else if (step) begin
      if (line_wrap) begin
        acc <= '0;
        bar <= '0;
      end else if (in_act) begin
        acc <= roll ? acc_inc - AW'(width) : acc_inc;
        bar <= roll ? bar + 1'b1 : bar;
      end
    end
  end

  // R7: visible pixels always map to one of the eight bars
  assert_bar_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_act |-> (bar < (BAR_LG+1)'(1 << BAR_LG)));

endmodule

// File: rtl/vid_raster_out.sv
module vid_raster_out
  import vid_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [11:0]   h_act,
  input  logic [11:0]   h_fp,
  input  logic [11:0]   h_sync,
  input  logic [11:0]   h_bp,
  input  logic [11:0]   v_act,
  input  logic [11:0]   v_fp,
  input  logic [11:0]   v_sync,
  input  logic [11:0]   v_bp,
  input  logic          hs_pol,
  input  logic          vs_pol,
  input  logic          test_en,
  input  logic          psave_en,
  input  logic          pix_valid,
  input  logic [23:0]   pix_data,
  output logic          pix_ready,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [23:0]   rgb,
  output logic          underflow
);

  axis_cfg_t hcfg_q, vcfg_q;
  logic      primed;
  logic      step_px, step_ln;
  logic      h_last, v_last;
  logic      frame_end, load;
  logic      vis_now, pull, starve;
  pos_t      hpos, vpos;
  region_e   h_reg, v_reg;
  logic [BAR_LG:0] bar;
  logic [23:0]     px_next;

  always_comb begin
    step_px   = primed && !psave_en;
    step_ln   = step_px && h_last;
    frame_end = step_ln && v_last;
    load      = !primed || frame_end;
    vis_now   = (h_reg == RG_ACT) && (v_reg == RG_ACT);
    pull      = step_px && vis_now && !test_en;
    starve    = pull && !pix_valid;
    pix_ready = pull;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcfg_q <= '0;
      vcfg_q <= '0;
    end else if (load) begin
      hcfg_q <= '{act: h_act, fp: h_fp, sy: h_sync, bp: h_bp, pol: hs_pol};
      vcfg_q <= '{act: v_act, fp: v_fp, sy: v_sync, bp: v_bp, pol: vs_pol};
    end
  end

  vid_axis_ctr u_hctr (
    .clk(clk), .rst_n(rst_n), .live(primed), .step(step_px),
    .cfg(hcfg_q), .pos(hpos), .last(h_last), .region(h_reg)
  );

  vid_axis_ctr u_vctr (
    .clk(clk), .rst_n(rst_n), .live(primed), .step(step_ln),
    .cfg(vcfg_q), .pos(vpos), .last(v_last), .region(v_reg)
  );

  vid_bar_gen u_bars (
    .clk(clk), .rst_n(rst_n), .step(step_px),
    .line_wrap(step_px && h_last), .in_act(h_reg == RG_ACT),
    .width(hcfg_q.act), .bar(bar)
  );

  always_comb begin
    if (!vis_now)       px_next = '0;
    else if (test_en)   px_next = bar_rgb(bar[BAR_LG-1:0]);
    else if (pix_valid) px_next = pix_data;
    else                px_next = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsync     <= 1'b0;
      vsync     <= 1'b0;
      de        <= 1'b0;
      rgb       <= '0;
      underflow <= 1'b0;
    end else if (primed) begin
      if (psave_en) begin
        hsync <= ~hcfg_q.pol;
        vsync <= ~vcfg_q.pol;
        de    <= 1'b0;
        rgb   <= '0;
      end else begin
        hsync     <= (h_reg == RG_SY) ? hcfg_q.pol : ~hcfg_q.pol;
        vsync     <= (v_reg == RG_SY) ? vcfg_q.pol : ~vcfg_q.pol;
        de        <= vis_now;
        rgb       <= px_next;
        underflow <= underflow || starve;
      end
    end
  end

  // R4: shadow geometry only moves at a load point
  assert_cfg_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(hcfg_q) && $stable(vcfg_q)));

  // R2: blanked output is black
  assert_blank_black_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !de |-> (rgb == '0));

  // R6: starvation flag never falls
  assert_uf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);

  // R7: test mode never pulls from upstream
  assert_test_no_pull_R7: assert property (@(posedge clk) disable iff (!rst_n)
    test_en |-> !pix_ready);

  // R8: power-save idles the pixel outputs
  assert_psave_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (psave_en && primed) |=> (!de && rgb == '0));

endmodule

// File: tb/vid_raster_out_tb.sv
`timescale 1ns/1ps
module vid_raster_out_tb;
  import vid_pkg::*;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic test_en, psave_en, pix_valid;
  logic [23:0] pix_data;
  logic pix_ready, hsync, vsync, de, underflow;
  logic [23:0] rgb;

  int l_ha, l_hf, l_hs, l_hb, l_va, l_vf, l_vs, l_vb;
  bit l_hp, l_vp;
  int s_ha, s_hf, s_hs, s_hb, s_va, s_vf, s_vs, s_vb;
  bit s_hp, s_vp;

  int mh, mv;
  bit mprimed;
  logic e_hs, e_vs, e_de, e_uf;
  logic [23:0] e_rgb;
  int vmode;
  string scen;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  vid_raster_out u_dut (
    .clk(clk), .rst_n(rst_n),
    .h_act(CW'(l_ha)), .h_fp(CW'(l_hf)), .h_sync(CW'(l_hs)), .h_bp(CW'(l_hb)),
    .v_act(CW'(l_va)), .v_fp(CW'(l_vf)), .v_sync(CW'(l_vs)), .v_bp(CW'(l_vb)),
    .hs_pol(l_hp), .vs_pol(l_vp), .test_en(test_en), .psave_en(psave_en),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
    .hsync(hsync), .vsync(vsync), .de(de), .rgb(rgb), .underflow(underflow)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s [%s] %s: actual %0h expected %0h (h=%0d v=%0d)",
               req, scen, what, act, exp, mh, mv);
    end
  endtask

  function automatic int reg_of(int p, int a, int f, int s);
    if (p < a) return 0;
    if (p < a + f) return 1;
    if (p < a + f + s) return 2;
    return 3;
  endfunction

  function automatic logic [23:0] bar_colour(int x, int w);
    int k;
    k = (8 * x) / w;
    return {{8{~k[1]}}, {8{~k[2]}}, {8{~k[0]}}};
  endfunction

  task automatic set_cfg(int ha, int hf, int hs, int hb, int va, int vf, int vs, int vb,
                         bit hp, bit vp);
    l_ha = ha; l_hf = hf; l_hs = hs; l_hb = hb;
    l_va = va; l_vf = vf; l_vs = vs; l_vb = vb;
    l_hp = hp; l_vp = vp;
  endtask

  task automatic load_shadow();
    s_ha = l_ha; s_hf = l_hf; s_hs = l_hs; s_hb = l_hb;
    s_va = l_va; s_vf = l_vf; s_vs = l_vs; s_vb = l_vb;
    s_hp = l_hp; s_vp = l_vp;
  endtask

  // R9: reset values, then release on a falling edge
  task automatic do_reset();
    rst_n = 1'b0;
    pix_valid = 1'b0; pix_data = '0;
    mprimed = 0; mh = 0; mv = 0;
    e_hs = 0; e_vs = 0; e_de = 0; e_uf = 0; e_rgb = '0;
    repeat (3) @(negedge clk);
    chk("R9", "reset hsync", 32'(hsync), 0);
    chk("R9", "reset vsync", 32'(vsync), 0);
    chk("R9", "reset de", 32'(de), 0);
    chk("R9", "reset rgb", 32'(rgb), 0);
    chk("R9", "reset underflow", 32'(underflow), 0);
    chk("R9", "reset ready", 32'(pix_ready), 0);
    rst_n = 1'b1;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      bit vis;
      bit want;
      int ht, vt;
      string rtag;
      pix_valid = (vmode == 0) ? 1'b1 : ((i % 3) != 0);
      pix_data = {8'(mh + 1), 8'(mv + 7), 8'(i)};
      #1;
      vis = mprimed && reg_of(mh, s_ha, s_hf, s_hs) == 0 && reg_of(mv, s_va, s_vf, s_vs) == 0;
      want = vis && !psave_en && !test_en;
      chk("R5", "pix_ready", 32'(pix_ready), 32'(want));
      rtag = test_en ? "R7" : (psave_en ? "R8" : "R5");
      if (!mprimed) begin
        load_shadow();
        mprimed = 1;
      end else if (psave_en) begin
        e_hs = ~s_hp; e_vs = ~s_vp; e_de = 0; e_rgb = '0;
      end else begin
        e_hs = (reg_of(mh, s_ha, s_hf, s_hs) == 2) ? s_hp : ~s_hp;
        e_vs = (reg_of(mv, s_va, s_vf, s_vs) == 2) ? s_vp : ~s_vp;
        e_de = vis;
        if (!vis) e_rgb = '0;
        else if (test_en) e_rgb = bar_colour(mh, s_ha);
        else e_rgb = pix_valid ? pix_data : 24'h0;
        if (want && !pix_valid) e_uf = 1;
        ht = s_ha + s_hf + s_hs + s_hb;
        vt = s_va + s_vf + s_vs + s_vb;
        if (mh == ht - 1) begin
          mh = 0;
          if (mv == vt - 1) begin
            mv = 0;
            load_shadow();
          end else mv++;
        end else mh++;
      end
      @(negedge clk);
      chk("R1,R3", "hsync", 32'(hsync), 32'(e_hs));
      chk("R1,R3", "vsync", 32'(vsync), 32'(e_vs));
      chk("R1,R2", "de", 32'(de), 32'(e_de));
      chk(rtag, "rgb", 32'(rgb), 32'(e_rgb));
      chk("R6", "underflow", 32'(underflow), 32'(e_uf));
    end
  endtask

  task automatic t_reset_R9();
    scen = "reset_R9";
    test_en = 0; psave_en = 0; vmode = 0;
    set_cfg(10, 2, 3, 4, 4, 1, 2, 1, 1, 1);
    do_reset();
    run(2);
  endtask

  task automatic t_basic_R1();
    scen = "basic_R1";
    set_cfg(10, 2, 3, 4, 4, 1, 2, 1, 1, 1);
    do_reset();
    run(19 * 8 * 2 + 5);
  endtask

  task automatic t_polarity_R3();
    scen = "polarity_R3";
    set_cfg(9, 1, 2, 1, 3, 2, 1, 2, 0, 1);
    do_reset();
    run(100);
    l_hp = 1; l_vp = 0;
    run(13 * 8 * 2);
  endtask

  task automatic t_reconfig_R4();
    scen = "reconfig_R4";
    set_cfg(10, 2, 3, 4, 4, 1, 2, 1, 1, 0);
    do_reset();
    run(50);
    set_cfg(12, 3, 1, 2, 2, 2, 3, 1, 0, 1);
    run(152 + 18 * 8 + 20);
  endtask

  task automatic t_underflow_R6();
    scen = "underflow_R6";
    set_cfg(10, 2, 3, 4, 4, 1, 2, 1, 1, 1);
    do_reset();
    vmode = 1;
    run(200);
    vmode = 0;
    run(60);
  endtask

  task automatic t_pattern_R7();
    scen = "pattern_R7";
    set_cfg(16, 2, 2, 2, 3, 1, 1, 1, 1, 1);
    do_reset();
    test_en = 1;
    run(22 * 6 * 2);
    test_en = 0;
    run(30);
  endtask

  task automatic t_psave_R8();
    scen = "psave_R8";
    set_cfg(10, 2, 3, 4, 4, 1, 2, 1, 1, 1);
    do_reset();
    run(27);
    psave_en = 1;
    run(20);
    psave_en = 0;
    run(200);
    psave_en = 1;
    run(5);
    psave_en = 0;
    run(40);
  endtask

  task automatic t_wide_R10();
    scen = "wide_R10";
    set_cfg(1920, 8, 12, 20, 3, 1, 1, 1, 1, 1);
    do_reset();
    run(1960 * 6 + 10);
    test_en = 1;
    run(1960 * 6);
    test_en = 0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 190000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog [%s]: actual running expected finished", scen);
    finish_up();
  end

  initial begin
    rst_n = 1'b0;
    test_en = 0; psave_en = 0; pix_valid = 0; pix_data = '0; vmode = 0;
    set_cfg(10, 2, 3, 4, 4, 1, 2, 1, 1, 1);
    @(negedge clk);
    t_reset_R9();
    t_basic_R1();
    t_polarity_R3();
    t_reconfig_R4();
    t_underflow_R6();
    t_pattern_R7();
    t_psave_R8();
    t_wide_R10();
    finish_up();
  end

endmodule